// File: doc/BRIEF.md
# Machine Control Register with Fault Qualification

This block holds the 32-bit machine-control word of a processor core and evaluates the fault and enable conditions that depend on it. Privileged software loads the word through a write port and reads it back through a read port. The hardware also sets the task-switched flag by itself when a task switch completes.

On every access the core presents a set of qualifiers: a floating-point instruction, a WAIT instruction, a write to a read-only page, the current privilege level, the alignment-check flag from the flags register, a misaligned access, and a fill request together with its cache-hit result. From these qualifiers and the register bits, the block produces the following outputs, all combinationally:
- the device-not-available fault (vector 7)
- the page write-protect fault
- the alignment fault
- the cache-fill grant
- the hit-serve indication
- the effective protected-mode enable
- the effective paging enable

Exception delivery, decode, the page tables and the cache array are outside this block.

Top module: `mcr_guard`

## Requirements
- R1: While rst_n is low at a clock edge the register becomes 0x00000010, and rd_data shows it from that edge on.
- R2: A cycle with wr_en high loads wr_data bits 0 (PE), 1 (MP), 2 (EM), 3 (TS), 16 (WP), 18 (AM), 30 (CD) and 31 (PG) into the register at that clock edge. rd_data presents the register directly.
- R3: Bit 4 always reads 1. Bits 5 and 29, and every bit not listed in R2, always read 0. Writes to any of these bits have no effect.
- R4: A cycle with task_switch high sets bit 3 (TS) at that edge. This takes priority over a write in the same cycle that clears TS; the other bits of that write still load.
- R5: dna_fault is high when fp_op is high and either EM (bit 2) or TS (bit 3) is 1.
- R6: dna_fault is also high when wait_op is high and both MP (bit 1) and TS are 1. MP alone never makes a floating-point instruction fault.
- R7: wp_fault is high when ro_write is high and either WP (bit 16) is 1 or cpl is 3.
- R8: align_fault is high only when AM (bit 18), flag_ac and misaligned are all 1 and cpl is 3.
- R9: fill_grant is high when fill_req is high, line_hit is low and CD (bit 30) is 0. hit_serve is high when fill_req and line_hit are both high, whatever the value of CD.
- R10: prot_en equals PE (bit 0). paging_en is high only when PG (bit 31) and PE are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Privileged register write strobe |
| wr_data | input | 32 | Value to write |
| rd_data | output | 32 | Current register value |
| task_switch | input | 1 | Task switch completed; sets TS |
| fp_op | input | 1 | Current instruction is floating-point |
| wait_op | input | 1 | Current instruction is WAIT |
| ro_write | input | 1 | Access is a write to a read-only page |
| cpl | input | 2 | Current privilege level (3 = user) |
| flag_ac | input | 1 | Alignment-check flag from the flags register |
| misaligned | input | 1 | Access is misaligned |
| fill_req | input | 1 | Cache fill request |
| line_hit | input | 1 | Requested line is present in the cache |
| dna_fault | output | 1 | Device-not-available fault (vector 7) |
| wp_fault | output | 1 | Page write-protect fault |
| align_fault | output | 1 | Alignment fault |
| fill_grant | output | 1 | A new cache fill may proceed |
| hit_serve | output | 1 | A hit is served from the cache |
| prot_en | output | 1 | Effective protected-mode enable |
| paging_en | output | 1 | Effective paging enable |

## Verification
The assertions check on every cycle the following properties:
- the fixed bits keep their values
- a task switch always leaves TS set
- a write lands with only its writable bits
- paging never appears without protected mode
- CD never allows a fill
- EM always faults floating-point instructions
- a WAIT fault always has MP and TS behind it

The full truth of each fault equation cannot be shown by these cycle checks. That truth comes only from the bench's sweep over all 256 settings of the writable bits, with all 512 qualifier patterns under each, and with junk in the fixed bits. The same holds for the same-cycle write and task-switch collision.

// File: rtl/mcr_pkg.sv
// Package: bit positions, masks and reset value of the machine-control word.
// Assumes a 32-bit word; all other modules take their layout from here.
package mcr_pkg;
    localparam int REG_W  = 32;
    localparam int CPL_W  = 2;

    localparam int BIT_PE = 0;
    localparam int BIT_MP = 1;
    localparam int BIT_EM = 2;
    localparam int BIT_TS = 3;
    localparam int BIT_ONE = 4;
    localparam int BIT_WP = 16;
    localparam int BIT_AM = 18;
    localparam int BIT_CD = 30;
    localparam int BIT_PG = 31;

    localparam logic [REG_W-1:0] WRITE_MASK =
        (REG_W'(1) << BIT_PE) | (REG_W'(1) << BIT_MP) |
        (REG_W'(1) << BIT_EM) | (REG_W'(1) << BIT_TS) |
        (REG_W'(1) << BIT_WP) | (REG_W'(1) << BIT_AM) |
        (REG_W'(1) << BIT_CD) | (REG_W'(1) << BIT_PG);
    localparam logic [REG_W-1:0] FIXED_ONES = REG_W'(1) << BIT_ONE;
    localparam logic [REG_W-1:0] RESET_VAL  = FIXED_ONES;
    localparam logic [CPL_W-1:0] USER_LVL   = {CPL_W{1'b1}};
endpackage

// File: rtl/mcr_store.sv
// mcr_store: holds the control word. Software writes land through the
// writable mask. Fixed bits are forced. A task switch sets TS with priority.
// Assumes synchronous active-low reset.
module mcr_store
    import mcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ts_set,
    output logic [REG_W-1:0] q
);
    logic [REG_W-1:0] nxt;

    // Next value: masked write, then hardware TS set on top.
    always_comb begin
        nxt = q;
        if (wr_en) nxt = (wr_data & WRITE_MASK) | FIXED_ONES;
        if (ts_set) nxt[BIT_TS] = 1'b1;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= nxt;
    end

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~WRITE_MASK) == FIXED_ONES); // R3
    AST_TS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ts_set |=> q[BIT_TS]); // R4
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ts_set) |=> (q == (($past(wr_data) & WRITE_MASK) | FIXED_ONES))); // R2
endmodule

// File: rtl/mcr_fault_eval.sv
// mcr_fault_eval: combinational fault qualification from the register bits
// and per-access qualifiers. Assumes qualifiers are valid in the same cycle.
module mcr_fault_eval
    import mcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mp,
    input  logic             em,
    input  logic             ts,
    input  logic             wp,
    input  logic             am,
    input  logic             fp_op,
    input  logic             wait_op,
    input  logic             ro_write,
    input  logic [CPL_W-1:0] cpl,
    input  logic             flag_ac,
    input  logic             misaligned,
    output logic             dna_fault,
    output logic             wp_fault,
    output logic             align_fault
);
    logic user_lvl;

    // Fault equations.
    always_comb begin
        user_lvl    = (cpl == USER_LVL);
        dna_fault   = (fp_op && (em || ts)) || (wait_op && mp && ts);
        wp_fault    = ro_write && (wp || user_lvl);
        align_fault = am && flag_ac && misaligned && user_lvl;
    end

    AST_EM_FP_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_op && em) |-> dna_fault); // R5
    AST_WAIT_NEEDS_MP: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_op && !fp_op && dna_fault) |-> (mp && ts)); // R6
    AST_ALIGN_USER: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (cpl == USER_LVL)); // R8
endmodule

// File: rtl/mcr_mode_gate.sv
// mcr_mode_gate: effective mode enables and cache fill gating.
// Assumes line_hit is meaningful only while fill_req is high.
module mcr_mode_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pe,
    input  logic pg,
    input  logic cd,
    input  logic fill_req,
    input  logic line_hit,
    output logic prot_en,
    output logic paging_en,
    output logic fill_grant,
    output logic hit_serve
);
    // Mode and cache gating.
    always_comb begin
        prot_en    = pe;
        paging_en  = pg && pe;
        fill_grant = fill_req && !line_hit && !cd;
        hit_serve  = fill_req && line_hit;
    end

    AST_PG_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n)
        paging_en |-> prot_en); // R10
    AST_CD_BLOCKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        cd |-> !fill_grant); // R9
endmodule

// File: rtl/mcr_guard.sv
// mcr_guard: top of the machine-control register block. Ties the storage,
// fault qualification and mode gating together. rd_data is the raw register.
module mcr_guard
    import mcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             task_switch,
    input  logic             fp_op,
    input  logic             wait_op,
    input  logic             ro_write,
    input  logic [CPL_W-1:0] cpl,
    input  logic             flag_ac,
    input  logic             misaligned,
    input  logic             fill_req,
    input  logic             line_hit,
    output logic             dna_fault,
    output logic             wp_fault,
    output logic             align_fault,
    output logic             fill_grant,
    output logic             hit_serve,
    output logic             prot_en,
    output logic             paging_en
);
    logic [REG_W-1:0] word;

    mcr_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ts_set(task_switch), .q(word)
    );

    mcr_fault_eval u_fault (
        .clk(clk), .rst_n(rst_n),
        .mp(word[BIT_MP]), .em(word[BIT_EM]), .ts(word[BIT_TS]),
        .wp(word[BIT_WP]), .am(word[BIT_AM]),
        .fp_op(fp_op), .wait_op(wait_op), .ro_write(ro_write), .cpl(cpl),
        .flag_ac(flag_ac), .misaligned(misaligned),
        .dna_fault(dna_fault), .wp_fault(wp_fault), .align_fault(align_fault)
    );

    mcr_mode_gate u_mode (
        .clk(clk), .rst_n(rst_n),
        .pe(word[BIT_PE]), .pg(word[BIT_PG]), .cd(word[BIT_CD]),
        .fill_req(fill_req), .line_hit(line_hit),
        .prot_en(prot_en), .paging_en(paging_en),
        .fill_grant(fill_grant), .hit_serve(hit_serve)
    );

    // Read port shows the register directly.
    always_comb rd_data = word;

    AST_RESET_VALUE: assert property (@(posedge clk)
        $past(!rst_n) && rst_n |-> rd_data == RESET_VAL); // R1
endmodule

// File: tb/mcr_guard_test.sv
module mcr_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        task_switch = 1'b0;
    logic        fp_op = 1'b0, wait_op = 1'b0, ro_write = 1'b0;
    logic [1:0]  cpl = 2'd0;
    logic        flag_ac = 1'b0, misaligned = 1'b0;
    logic        fill_req = 1'b0, line_hit = 1'b0;
    logic        dna_fault, wp_fault, align_fault, fill_grant, hit_serve;
    logic        prot_en, paging_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] WMASK = 32'hC005_000F;

    always #4 clk = ~clk;

    mcr_guard uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .task_switch(task_switch), .fp_op(fp_op),
        .wait_op(wait_op), .ro_write(ro_write), .cpl(cpl), .flag_ac(flag_ac),
        .misaligned(misaligned), .fill_req(fill_req), .line_hit(line_hit),
        .dna_fault(dna_fault), .wp_fault(wp_fault), .align_fault(align_fault),
        .fill_grant(fill_grant), .hit_serve(hit_serve), .prot_en(prot_en),
        .paging_en(paging_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] w, input logic ts);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w; task_switch = ts;
        @(negedge clk);
        wr_en = 1'b0; task_switch = 1'b0;
    endtask

    function automatic logic [31:0] expand(input logic [7:0] c);
        logic [31:0] w = '0;
        w[0] = c[0]; w[1] = c[1]; w[2] = c[2]; w[3] = c[3];
        w[16] = c[4]; w[18] = c[5]; w[30] = c[6]; w[31] = c[7];
        return w;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset value", rd_data, 32'h0000_0010);
        check("R10 prot_en after reset", {31'd0, prot_en}, 32'd0);

        write_word(32'hFFFF_FFFF, 1'b0);
        check("R2/R3 all-ones write", rd_data, 32'hC005_001F);
        write_word(32'h0000_0000, 1'b0);
        check("R3 zero write keeps bit4", rd_data, 32'h0000_0010);
        write_word(32'h0000_0000, 1'b1);
        check("R4 task switch sets TS", rd_data, 32'h0000_0018);
        write_word(32'h8000_0001, 1'b1);
        check("R4 TS wins over clearing write", rd_data, 32'h8000_0019);
        @(negedge clk); task_switch = 1'b1; @(negedge clk); task_switch = 1'b0;
        check("R4 lone task switch", rd_data, 32'h8000_0019);

        for (int c = 0; c < 256; c++) begin
            logic [31:0] w;
            logic pe, mp, em, ts, wp, am, cd, pg;
            w = expand(8'(c));
            if (c[0]) w = w | ~WMASK;
            write_word(w, 1'b0);
            check("R2/R3 readback", rd_data, (w & WMASK) | 32'h10);
            pe = c[0]; mp = c[1]; em = c[2]; ts = c[3];
            wp = c[4]; am = c[5]; cd = c[6]; pg = c[7];
            for (int v = 0; v < 512; v++) begin
                logic user;
                fp_op = v[0]; wait_op = v[1]; ro_write = v[2];
                cpl = 2'(v >> 3); flag_ac = v[5]; misaligned = v[6];
                fill_req = v[7]; line_hit = v[8];
                #1;
                user = (cpl == 2'd3);
                check("R5/R6 dna_fault", {31'd0, dna_fault},
                      {31'd0, (fp_op & (em | ts)) | (wait_op & mp & ts)});
                check("R7 wp_fault", {31'd0, wp_fault}, {31'd0, ro_write & (wp | user)});
                check("R8 align_fault", {31'd0, align_fault},
                      {31'd0, am & flag_ac & misaligned & user});
                check("R9 fill_grant", {31'd0, fill_grant},
                      {31'd0, fill_req & ~line_hit & ~cd});
                check("R9 hit_serve", {31'd0, hit_serve}, {31'd0, fill_req & line_hit});
                check("R10 prot_en", {31'd0, prot_en}, {31'd0, pe});
                check("R10 paging_en", {31'd0, paging_en}, {31'd0, pg & pe});
            end
        end

        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        check("R1 reset after traffic", rd_data, 32'h0000_0010);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule